// File: doc/BRIEF.md
# Color Plane Remapper with Committed Padding

This block sits in a pixel stream and builds every output pixel from a fixed
selection of the incoming color planes. Each output plane carries a mapping
code fixed at build time: it either copies one input plane, emits zero when
the code names an input plane the stream does not carry, or emits a padding
constant held in a register. The stream has valid, ready, start-of-packet and
end-of-packet, and passes through exactly one register stage with no bubbles.

Software sets padding constants through a 32-bit memory-mapped register port.
The constants are double-buffered. A write lands in a staging copy. Writing 1
to the commit bit arms a handover. The staged values then become active on
the next start-of-frame beat, and that beat already uses them. A status
register shows whether a frame is in progress and whether padding writes are
still waiting for a handover. Read-only registers report an identity word and
the build parameters.

Top module: `cplane_remap`

## Requirements
- R1: A mapping code c with c < N_IN copies input plane c. Plane k sits in bits [k*SYM_W +: SYM_W] of both the input and the output data bus. The default map is output 0 from input 2, output 1 from input 0, output 2 code 3, output 3 code 4, with N_IN = 3.
- R2: Code 4 drives the active padding value of that plane. A code from N_IN to 3 drives zero.
- R3: A padding write, even after a commit, never changes an output plane whose code is not 4.
- R4: A padding write is invisible until 1 is written to bit 0 of 0x144 and a beat with start-of-packet is then accepted. That beat already carries the new value. Without a commit, a later start-of-packet keeps the old value.
- R5: Status (0x140) bit 0 is 1 after a start-of-packet beat is accepted and 0 after an end-of-packet beat is accepted.
- R6: Status bit 1 is set by a write to a padding register (0x148, 0x14C, 0x150, 0x154 for planes 0 to 3). It clears at the handover. A padding write in the same cycle as the handover sets it again and stays staged, not active.
- R7: 0x000 reads 0x6AF7023B. 0x010 reads SYM_W, 0x018 reads N_IN and 0x01C reads N_OUT. 0x020 + 4k reads the mapping code of plane k.
- R8: Reserved offsets and the commit register read 0. Writes to read-only offsets are ignored.
- R9: in_ready is 1 when out_valid is 0 or out_ready is 1. An accepted beat appears on the output in the next cycle with its sop and eop. A stalled output holds its data and flags.
- R10: Read data and reg_rvalid appear in the cycle after reg_rd. After reset out_valid is 0 and the status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts a beat |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_data | input | N_IN*SYM_W | Input planes |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts |
| out_sop | output | 1 | First beat of a frame |
| out_eop | output | 1 | Last beat of a frame |
| out_data | output | N_OUT*SYM_W | Output planes |
| reg_addr | input | ADDR_W | Byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| reg_rvalid | output | 1 | Read data valid |

## Verification
The assertions assume the upstream holds a beat steady until it is accepted.
They also assume that reads and writes are single-cycle strobes that never
overlap. The stimulus keeps in_valid asserted through a stall and changes the
beat only after acceptance. It issues one register access at a time, except
in the deliberate test where a padding write meets a start-of-frame beat,
which is a stream event and not a register conflict.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  localparam logic [31:0] CPR_ID      = 32'h6AF7_023B;
  localparam logic [31:0] CPR_VERSION = 32'h0101_0001;
  localparam int          CODE_W      = 3;
  localparam logic [2:0]  CODE_PAD    = 3'd4;
  // word offsets (byte offset / 4)
  localparam int W_ID      = 'h00;
  localparam int W_VER     = 'h01;
  localparam int W_LITE    = 'h02;
  localparam int W_DBG     = 'h03;
  localparam int W_SYMW    = 'h04;
  localparam int W_PIP     = 'h05;
  localparam int W_NIN     = 'h06;
  localparam int W_NOUT    = 'h07;
  localparam int W_MAP0    = 'h08;
  localparam int W_STATUS  = 'h50;
  localparam int W_COMMIT  = 'h51;
  localparam int W_PAD0    = 'h52;
endpackage

// File: rtl/cpr_pipe.sv
module cpr_pipe
  import cpr_pkg::*;
#(
  parameter int SYM_W = 8,
  parameter int N_IN  = 3,
  parameter int N_OUT = 4,
  parameter logic [4*CODE_W-1:0] MAP = {3'd4, 3'd3, 3'd0, 3'd2}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_sop,
  input  logic                   in_eop,
  input  logic [N_IN*SYM_W-1:0]  in_data,
  input  logic [N_OUT*SYM_W-1:0] pad_use,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic                   out_sop,
  output logic                   out_eop,
  output logic [N_OUT*SYM_W-1:0] out_data
);
  logic [N_OUT*SYM_W-1:0] mapped;

  for (genvar k = 0; k < N_OUT; k++) begin : g_plane
    localparam int CODE = int'(MAP[k*CODE_W +: CODE_W]);
    if (CODE < N_IN) begin : g_copy
      assign mapped[k*SYM_W +: SYM_W] = in_data[CODE*SYM_W +: SYM_W];
    end else if (CODE == int'(CODE_PAD)) begin : g_pad
      assign mapped[k*SYM_W +: SYM_W] = pad_use[k*SYM_W +: SYM_W];
    end else begin : g_zero
      assign mapped[k*SYM_W +: SYM_W] = '0;
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      out_sop   <= in_sop;
      out_eop   <= in_eop;
      out_data  <= mapped;
    end
  end
endmodule

// File: rtl/cpr_regs.sv
module cpr_regs
  import cpr_pkg::*;
#(
  parameter int SYM_W  = 8,
  parameter int N_IN   = 3,
  parameter int N_OUT  = 4,
  parameter int ADDR_W = 9,
  parameter logic [4*CODE_W-1:0] MAP = {3'd4, 3'd3, 3'd0, 3'd2}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic                   reg_wr,
  input  logic [31:0]            reg_wdata,
  input  logic                   reg_rd,
  output logic [31:0]            reg_rdata,
  output logic                   reg_rvalid,
  input  logic                   beat_acc,
  input  logic                   beat_sop,
  input  logic                   beat_eop,
  output logic [N_OUT*SYM_W-1:0] pad_use
);
  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0]  word;
  logic             aligned;
  logic [SYM_W-1:0] staged [N_OUT];
  logic [SYM_W-1:0] active [N_OUT];
  logic             armed, pending, busy;
  logic             handover, pad_wr, commit_wr;
  logic [31:0]      rd_mux;

  assign word      = reg_addr[ADDR_W-1:2];
  assign aligned   = (reg_addr[1:0] == 2'b00);
  assign handover  = beat_acc && beat_sop && armed;
  assign commit_wr = reg_wr && aligned && word == WA_W'(W_COMMIT) && reg_wdata[0];
  assign pad_wr    = reg_wr && aligned && word >= WA_W'(W_PAD0)
                     && word < WA_W'(W_PAD0 + N_OUT);

  for (genvar k = 0; k < N_OUT; k++) begin : g_pad
    assign pad_use[k*SYM_W +: SYM_W] = handover ? staged[k] : active[k];
    always_ff @(posedge clk) begin
      if (rst) begin
        staged[k] <= '0;
        active[k] <= '0;
      end else begin
        if (handover) active[k] <= staged[k];
        if (reg_wr && aligned && word == WA_W'(W_PAD0 + k))
          staged[k] <= reg_wdata[SYM_W-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (int'(word))
        W_ID:     rd_mux = CPR_ID;
        W_VER:    rd_mux = CPR_VERSION;
        W_LITE:   rd_mux = 32'd1;
        W_DBG:    rd_mux = 32'd0;
        W_SYMW:   rd_mux = 32'(SYM_W);
        W_PIP:    rd_mux = 32'd1;
        W_NIN:    rd_mux = 32'(N_IN);
        W_NOUT:   rd_mux = 32'(N_OUT);
        W_STATUS: rd_mux = {30'd0, pending, busy};
        default:  rd_mux = '0;
      endcase
      for (int k = 0; k < N_OUT; k++) begin
        if (word == WA_W'(W_MAP0 + k)) rd_mux = 32'(MAP[k*CODE_W +: CODE_W]);
        if (word == WA_W'(W_PAD0 + k)) rd_mux = 32'(staged[k]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b0;
      pending    <= 1'b0;
      busy       <= 1'b0;
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
      if (handover) armed <= 1'b0;
      if (commit_wr) armed <= 1'b1;
      if (pad_wr) pending <= 1'b1;
      else if (handover) pending <= 1'b0;
      if (beat_acc) begin
        if (beat_eop) busy <= 1'b0;
        else if (beat_sop) busy <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cplane_remap.sv
module cplane_remap
  import cpr_pkg::*;
#(
  parameter int SYM_W  = 8,
  parameter int N_IN   = 3,
  parameter int N_OUT  = 4,
  parameter int ADDR_W = 9,
  parameter logic [4*CODE_W-1:0] MAP = {3'd4, 3'd3, 3'd0, 3'd2}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_sop,
  input  logic                   in_eop,
  input  logic [N_IN*SYM_W-1:0]  in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic                   out_sop,
  output logic                   out_eop,
  output logic [N_OUT*SYM_W-1:0] out_data,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic                   reg_wr,
  input  logic [31:0]            reg_wdata,
  input  logic                   reg_rd,
  output logic [31:0]            reg_rdata,
  output logic                   reg_rvalid
);
  logic [N_OUT*SYM_W-1:0] pad_use;
  logic                   ready_i;

  assign in_ready = ready_i;

  cpr_regs #(.SYM_W(SYM_W), .N_IN(N_IN), .N_OUT(N_OUT), .ADDR_W(ADDR_W), .MAP(MAP)) u_regs (
    .clk(clk), .rst(rst),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .beat_acc(in_valid && ready_i), .beat_sop(in_sop), .beat_eop(in_eop),
    .pad_use(pad_use)
  );

  cpr_pipe #(.SYM_W(SYM_W), .N_IN(N_IN), .N_OUT(N_OUT), .MAP(MAP)) u_pipe (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(ready_i), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .pad_use(pad_use),
    .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
    .out_eop(out_eop), .out_data(out_data)
  );
endmodule

// File: rtl/cpr_checker.sv
module cpr_checker
  import cpr_pkg::*;
#(
  parameter int SYM_W  = 8,
  parameter int N_IN   = 3,
  parameter int N_OUT  = 4,
  parameter int ADDR_W = 9,
  parameter logic [4*CODE_W-1:0] MAP = {3'd4, 3'd3, 3'd0, 3'd2}
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [N_IN*SYM_W-1:0]  in_data,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic                   out_sop,
  input logic                   out_eop,
  input logic [N_OUT*SYM_W-1:0] out_data,
  input logic [ADDR_W-1:0]      reg_addr,
  input logic                   reg_rd,
  input logic [31:0]            reg_rdata,
  input logic                   reg_rvalid
);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));
  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);
  p_accept_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);
  p_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);
  p_ident_r7: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr == '0 |=> reg_rdata == CPR_ID);

  for (genvar k = 0; k < N_OUT; k++) begin : g_chk
    localparam int CODE = int'(MAP[k*CODE_W +: CODE_W]);
    if (CODE < N_IN) begin : g_copy
      p_route_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_data[k*SYM_W +: SYM_W] == $past(in_data[CODE*SYM_W +: SYM_W]));
    end else if (CODE != int'(CODE_PAD)) begin : g_zero
      p_zero_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_data[k*SYM_W +: SYM_W] == '0);
    end
  end
endmodule

bind cplane_remap cpr_checker #(.SYM_W(SYM_W), .N_IN(N_IN), .N_OUT(N_OUT), .ADDR_W(ADDR_W), .MAP(MAP)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop), .out_eop(out_eop),
  .out_data(out_data), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .reg_rvalid(reg_rvalid)
);

// File: tb/cplane_remap_bench.sv
module cplane_remap_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 0, in_sop = 0, in_eop = 0, out_ready = 1;
  logic [23:0] in_data = '0;
  logic        in_ready, out_valid, out_sop, out_eop, reg_rvalid;
  logic [31:0] out_data, reg_rdata;
  logic [8:0]  reg_addr = '0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = '0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cplane_remap u_cplane_remap (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid)
  );

  // {input beat, expected output with padding 0}: out = {pad3, 0, in0, in2}
  localparam logic [55:0] VEC [4] = '{
    {24'h33_22_11, 32'h00_00_11_33},
    {24'hFF_00_80, 32'h00_00_80_FF},
    {24'h01_FE_7F, 32'h00_00_7F_01},
    {24'hAA_55_C3, 32'h00_00_C3_AA}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(negedge clk); reg_rd = 0;
    check("R10 rvalid", 32'(reg_rvalid), 32'd1);
    d = reg_rdata;
  endtask

  task automatic beat(input logic [23:0] d, input logic s, input logic e);
    @(negedge clk); in_data = d; in_sop = s; in_eop = e; in_valid = 1;
    @(negedge clk); in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R10 reset out_valid", 32'(out_valid), 0);
    check("R9 reset in_ready", 32'(in_ready), 1);
    rd(9'h140, v); check("R10 reset status", v, 0);

    // table walk, R1 R2
    foreach (VEC[i]) begin
      beat(VEC[i][55:32], 0, 0);
      check("R1 R2 mapping", out_data, VEC[i][31:0]);
    end

    // R7 identity and parameters
    rd(9'h000, v); check("R7 id", v, 32'h6AF7023B);
    rd(9'h010, v); check("R7 symbol width", v, 8);
    rd(9'h018, v); check("R7 inputs", v, 3);
    rd(9'h01C, v); check("R7 outputs", v, 4);
    rd(9'h020, v); check("R7 map0", v, 2);
    rd(9'h02C, v); check("R7 map3", v, 4);
    // R8 reserved and read-only
    rd(9'h030, v); check("R8 reserved", v, 0);
    wr(9'h000, 32'h1234_5678);
    wr(9'h01C, 32'd9);
    rd(9'h000, v); check("R8 ro id", v, 32'h6AF7023B);
    rd(9'h01C, v); check("R8 ro outputs", v, 4);

    // R4 R6 R5 padding handover
    wr(9'h154, 32'hA5);
    rd(9'h140, v); check("R6 pending set", v, 2);
    beat(24'h030201, 1, 0);
    check("R4 no commit keeps pad", out_data, 32'h00_00_01_03);
    beat(24'h030201, 0, 1);
    wr(9'h144, 32'h1);
    beat(24'h030201, 0, 0);
    check("R4 commit waits for sop", out_data, 32'h00_00_01_03);
    beat(24'h030201, 1, 0);
    check("R4 sop beat uses new pad", out_data, 32'hA5_00_01_03);
    rd(9'h140, v); check("R5 R6 busy, pending clear", v, 1);
    rd(9'h144, v); check("R8 commit reads 0", v, 0);
    beat(24'h030201, 0, 1);
    rd(9'h140, v); check("R5 idle after eop", v, 0);

    // R3 pad on a copied plane is ignored
    wr(9'h148, 32'h77); wr(9'h150, 32'h66); wr(9'h144, 32'h1);
    beat(24'h0C0B0A, 1, 1);
    check("R3 R2 non-pad planes", out_data, 32'hA5_00_0A_0C);

    // R6 pad write concurrent with handover
    wr(9'h154, 32'h3C); wr(9'h144, 32'h1);
    @(negedge clk);
    in_data = 24'h030201; in_sop = 1; in_eop = 1; in_valid = 1;
    reg_addr = 9'h154; reg_wdata = 32'h11; reg_wr = 1;
    @(negedge clk); in_valid = 0; in_sop = 0; in_eop = 0; reg_wr = 0;
    check("R6 R4 handover value", out_data, 32'h3C_00_01_03);
    rd(9'h140, v); check("R6 pending re-set", v, 2);
    beat(24'h030201, 1, 1);
    check("R4 no commit after write", out_data, 32'h3C_00_01_03);
    wr(9'h144, 32'h1);
    beat(24'h030201, 1, 1);
    check("R4 late write committed", out_data, 32'h11_00_01_03);

    // R9 backpressure
    @(negedge clk); out_ready = 0; in_data = 24'h112233; in_sop = 1; in_valid = 1;
    @(negedge clk);
    check("R9 valid", 32'(out_valid), 1);
    check("R9 stall blocks input", 32'(in_ready), 0);
    in_data = 24'h445566;
    @(negedge clk);
    check("R9 held data", out_data, 32'h11_00_33_11);
    check("R9 held sop", 32'(out_sop), 1);
    out_ready = 1;
    @(negedge clk); in_valid = 0; in_sop = 0;
    check("R9 next beat", out_data, 32'h11_00_66_44);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule